// File: doc/BRIEF.md
# Receive Destination Filter

This block sits on the receive byte stream of an Ethernet MAC and decides, for every frame, whether the frame is kept or dropped. It looks at the six-byte destination address and, if requested, at the frame's leading bytes. The decision is a single accept/reject result with a code that names the rule that caught the frame. The rules are: accept every broadcast, every multicast or every unicast frame; an exact compare against one station address whose top bits can be excluded; a 2048-bit hash table lookup for group and individual addresses; and up to four byte-pattern matchers.

The station address, the pattern words and the hash table live in one store. Software reaches it through a 10-bit address and a 16-bit data word. The rule enables and the address mask width are plain control pins, and they are expected to stay constant while a frame is in flight.

Bytes enter on a valid/ready stream, with a start strobe on the first byte and an end strobe on the last. The decision leaves on a valid/ready pair. While a decision waits to be taken, `in_ready` stays low, so no further byte is consumed until the consumer raises `dec_ready`.

Top module: `rx_addr_filter`

## Requirements
- R1: A byte is consumed on a clock edge with `in_valid` and `in_ready` both high. `in_ready` is low exactly while `dec_valid` is high. `dec_valid`, `dec_accept` and `dec_kind` stay unchanged until they are taken on an edge with `dec_ready` high. Bytes that arrive outside a frame (after an end strobe and before the next start strobe) are ignored.
- R2: When no pattern matcher is enabled, the decision is registered on the edge that consumes the sixth byte of the frame. When any pattern matcher is enabled, it is registered on the edge that consumes the end-strobed byte. A frame that ends before six bytes gets a reject at its end. Exactly one decision is made per frame.
- R3: With `flt_en` low, every frame is rejected with code 0.
- R4: The destination is broadcast when all 48 bits are one. With `acc_bcast` high, a broadcast frame is accepted with code 1.
- R5: The destination is multicast when bit 0 of the first byte is set and the destination is not broadcast. With `acc_mcast` high, a multicast frame is accepted with code 2. A broadcast frame is not caught by this rule.
- R6: The destination is unicast when bit 0 of the first byte is clear. With `acc_ucast` high, a unicast frame is accepted with code 3.
- R7: The station address is held in words 0x000 to 0x002. Word k holds byte 2k in bits 7:0 and byte 2k+1 in bits 15:8, where byte 0 is the first byte on the wire. The destination is treated as a 48-bit value with byte 0 in bits 47:40. With `perf_en` high, the frame is accepted with code 4 when every bit j with j < 48 − `perf_mask` equals the stored address. A mask of 48 or more makes every address match.
- R8: The hash index is the 11 most significant bits of a CRC-32 register. The register starts at all ones, uses the reflected polynomial 0xEDB88320, and takes the six destination bytes in wire order, least significant bit first, with no final inversion. Index i lives at word 0x200 + i[10:4], bit i[3:0]. A set bit accepts with code 5 when the destination is a group address (bit 0 of byte 0 set, broadcast included) and `hash_mc_en` is high, or when it is individual and `hash_uc_en` is high.
- R9: Pattern p (0 to 3) word i sits at address 0x100 + 64·p + i. Bits 7:0 of the word hold the byte value, bit 8 is the compare enable and bit 9 marks the last word. Word i is compared with frame byte i. An enabled pattern hits when its last word is reached within the frame and no enabled compare up to and including that word failed. Any hit accepts with code 6.
- R10: A frame is accepted when any enabled rule hits. The code reported is the lowest-numbered rule that hits, in the order 1 to 6. A rejected frame reports code 0.
- R11: Reading returns the stored value at station, pattern and hash addresses, on `cfg_rdata` combinationally from `cfg_addr`. Pattern words read back only bits 9:0. Writes to any other address are ignored and reads there return 0. All words are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte present |
| in_ready | output | 1 | Byte can be consumed |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| dec_valid | output | 1 | Decision present |
| dec_ready | input | 1 | Consumer takes the decision |
| dec_accept | output | 1 | Frame kept |
| dec_kind | output | 3 | Rule that hit (0 none, 1..6) |
| flt_en | input | 1 | Global filter enable |
| acc_bcast | input | 1 | Accept all broadcast |
| acc_mcast | input | 1 | Accept all multicast |
| acc_ucast | input | 1 | Accept all unicast |
| perf_en | input | 1 | Station address compare enable |
| perf_mask | input | 6 | Count of excluded top address bits |
| hash_mc_en | input | 1 | Hash lookup for group addresses |
| hash_uc_en | input | 1 | Hash lookup for individual addresses |
| pat_en | input | 4 | Per-pattern enable |
| cfg_we | input | 1 | Store write strobe |
| cfg_addr | input | 10 | Store word address |
| cfg_wdata | input | 16 | Store write data |
| cfg_rdata | output | 16 | Store read data |

## Verification
The main function is tried with broadcast, multicast, unicast and station-address destinations, each under a rule set where exactly one rule could catch it. This tells apart rules that are easy to confuse, such as broadcast versus multicast and group-address hashing versus individual-address hashing. Masked and unmasked station compares, in which only a top bit differs, show that the mask counts from the most significant end. Pattern frames that match, mismatch on one byte, or end one byte before the last word separate the compare check from the last-word check. Overlapping rule sets confirm the reporting priority. Loose bytes outside a frame, short frames, back-to-back frames and a consumer that holds off for several cycles exercise the stall and single-decision rules against a behavioural model that is compared on every clock.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int CFG_AW   = 10;
  localparam int CFG_DW   = 16;
  localparam int PW       = 10;
  localparam int PAT_CARE = 8;
  localparam int PAT_LAST = 9;
  localparam int DA_BYTES = 6;
  localparam int DA_BITS  = 8 * DA_BYTES;

  typedef enum logic [2:0] {
    HIT_NONE    = 3'd0,
    HIT_BCAST   = 3'd1,
    HIT_MCAST   = 3'd2,
    HIT_UCAST   = 3'd3,
    HIT_PERFECT = 3'd4,
    HIT_HASH    = 3'd5,
    HIT_PATTERN = 3'd6
  } hit_kind_t;

  // reflected CRC-32 over one byte, least significant bit first
  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    logic fb;
    r = c;
    for (int k = 0; k < 8; k++) begin
      fb = r[0] ^ b[k];
      r  = r >> 1;
      if (fb) r = r ^ 32'hEDB88320;
    end
    return r;
  endfunction
endpackage

// File: rtl/rxf_store.sv
module rxf_store
  import rxf_pkg::*;
#(
  parameter int NPAT      = 4,
  parameter int PAT_LEN   = 64,
  parameter int HASH_BITS = 2048,
  parameter int BASE_PAT  = 256,
  parameter int BASE_HASH = 512
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cfg_we,
  input  logic [CFG_AW-1:0]                   cfg_addr,
  input  logic [CFG_DW-1:0]                   cfg_wdata,
  output logic [CFG_DW-1:0]                   cfg_rdata,
  output logic [DA_BITS-1:0]                  perf_addr,
  input  logic [$clog2(PAT_LEN)-1:0]          pat_idx,
  output logic [NPAT-1:0][PW-1:0]             pat_word,
  input  logic [$clog2(HASH_BITS)-1:0]        hash_idx,
  output logic                                hash_bit
);
  localparam int PAT_IW     = $clog2(PAT_LEN);
  localparam int PSEL_W     = $clog2(NPAT);
  localparam int HASH_IW    = $clog2(HASH_BITS);
  localparam int HASH_WORDS = HASH_BITS / CFG_DW;
  localparam int HWSEL_W    = $clog2(HASH_WORDS);
  localparam int WSEL_W     = $clog2(CFG_DW);

  logic [CFG_DW-1:0] perf0_q, perf1_q, perf2_q;
  logic [NPAT-1:0][PAT_LEN-1:0][PW-1:0] pat_mem;
  logic [HASH_WORDS-1:0][CFG_DW-1:0]    hash_mem;

  logic [CFG_AW-1:0] pat_off, hash_off;
  logic              is_perf, is_pat, is_hash;
  logic [PSEL_W-1:0] pat_p;
  logic [PAT_IW-1:0] pat_i;
  logic [HWSEL_W-1:0] hash_w;

  assign pat_off  = cfg_addr - CFG_AW'(BASE_PAT);
  assign hash_off = cfg_addr - CFG_AW'(BASE_HASH);
  assign is_perf  = (32'(cfg_addr) < 3);
  assign is_pat   = (32'(cfg_addr) >= BASE_PAT)  && (32'(cfg_addr) < BASE_PAT + NPAT * PAT_LEN);
  assign is_hash  = (32'(cfg_addr) >= BASE_HASH) && (32'(cfg_addr) < BASE_HASH + HASH_WORDS);
  assign pat_p    = pat_off[PAT_IW +: PSEL_W];
  assign pat_i    = pat_off[PAT_IW-1:0];
  assign hash_w   = hash_off[HWSEL_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perf0_q  <= '0;
      perf1_q  <= '0;
      perf2_q  <= '0;
      pat_mem  <= '0;
      hash_mem <= '0;
    end else if (cfg_we) begin
      if (is_perf) begin
        case (cfg_addr[1:0])
          2'd0:    perf0_q <= cfg_wdata;
          2'd1:    perf1_q <= cfg_wdata;
          default: perf2_q <= cfg_wdata;
        endcase
      end
      if (is_pat)  pat_mem[pat_p][pat_i] <= cfg_wdata[PW-1:0];
      if (is_hash) hash_mem[hash_w]      <= cfg_wdata;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (is_perf) begin
      case (cfg_addr[1:0])
        2'd0:    cfg_rdata = perf0_q;
        2'd1:    cfg_rdata = perf1_q;
        default: cfg_rdata = perf2_q;
      endcase
    end else if (is_pat) begin
      cfg_rdata = CFG_DW'(pat_mem[pat_p][pat_i]);
    end else if (is_hash) begin
      cfg_rdata = hash_mem[hash_w];
    end
  end

  assign perf_addr = {perf0_q[7:0], perf0_q[15:8], perf1_q[7:0],
                      perf1_q[15:8], perf2_q[7:0], perf2_q[15:8]};

  assign hash_bit = hash_mem[hash_idx[HASH_IW-1 -: HWSEL_W]][hash_idx[WSEL_W-1:0]];

  for (genvar p = 0; p < NPAT; p++) begin : g_patrd
    assign pat_word[p] = pat_mem[p][pat_idx];
  end
endmodule

// File: rtl/rxf_pat_lane.sv
module rxf_pat_lane
  import rxf_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          start,
  input  logic          beyond,
  input  logic [7:0]    data,
  input  logic [PW-1:0] word,
  output logic          hit_now
);
  logic alive_q, done_q;
  logic alive_b, done_b, alive_n, done_n, miss;

  assign alive_b = start ? 1'b1 : alive_q;
  assign done_b  = start ? 1'b0 : done_q;
  assign miss    = !beyond && !done_b && word[PAT_CARE] && (word[7:0] != data);
  assign alive_n = alive_b && !miss;
  assign done_n  = done_b || (!beyond && word[PAT_LAST]);
  assign hit_now = alive_n && done_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alive_q <= 1'b0;
      done_q  <= 1'b0;
    end else if (take) begin
      alive_q <= alive_n;
      done_q  <= done_n;
    end
  end

  // a pattern can only be lost on a consumed byte (R9)
  assert_alive_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alive_q) |-> $past(take))
    else $error("pattern state dropped without a consumed byte");
endmodule

// File: rtl/rxf_da_check.sv
module rxf_da_check
  import rxf_pkg::*;
(
  input  logic               flt_en,
  input  logic               da_ok,
  input  logic [DA_BITS-1:0] da,
  input  logic [DA_BITS-1:0] perf_addr,
  input  logic [5:0]         perf_mask,
  input  logic               acc_bcast,
  input  logic               acc_mcast,
  input  logic               acc_ucast,
  input  logic               perf_en,
  input  logic               hash_mc_en,
  input  logic               hash_uc_en,
  input  logic               hash_bit,
  input  logic               pat_hit,
  output logic               accept,
  output hit_kind_t          kind
);
  logic [DA_BITS-1:0] care;
  logic bcast, grp, perf_hit, hash_hit;

  always_comb begin
    for (int j = 0; j < DA_BITS; j++)
      care[j] = (j + int'(perf_mask)) < DA_BITS;
  end

  assign bcast    = &da;
  assign grp      = da[DA_BITS-8];
  assign perf_hit = perf_en && (((da ^ perf_addr) & care) == '0);
  assign hash_hit = hash_bit && ((grp && hash_mc_en) || (!grp && hash_uc_en));

  always_comb begin
    kind = HIT_NONE;
    if (flt_en && da_ok) begin
      if (bcast && acc_bcast)               kind = HIT_BCAST;
      else if (grp && !bcast && acc_mcast)  kind = HIT_MCAST;
      else if (!grp && acc_ucast)           kind = HIT_UCAST;
      else if (perf_hit)                    kind = HIT_PERFECT;
      else if (hash_hit)                    kind = HIT_HASH;
      else if (pat_hit)                     kind = HIT_PATTERN;
    end
    accept = (kind != HIT_NONE);
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int NPAT      = 4,
  parameter int PAT_LEN   = 64,
  parameter int HASH_BITS = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  output logic              dec_valid,
  input  logic              dec_ready,
  output logic              dec_accept,
  output logic [2:0]        dec_kind,
  input  logic              flt_en,
  input  logic              acc_bcast,
  input  logic              acc_mcast,
  input  logic              acc_ucast,
  input  logic              perf_en,
  input  logic [5:0]        perf_mask,
  input  logic              hash_mc_en,
  input  logic              hash_uc_en,
  input  logic [NPAT-1:0]   pat_en,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [CFG_DW-1:0] cfg_rdata
);
  localparam int PAT_IW  = $clog2(PAT_LEN);
  localparam int CNT_W   = PAT_IW + 1;
  localparam int HASH_IW = $clog2(HASH_BITS);
  localparam logic [CNT_W-1:0] LAST_DA = CNT_W'(DA_BYTES - 1);

  logic               in_frame_q, decided_q, dec_valid_q, dec_accept_q;
  hit_kind_t          dec_kind_q;
  logic [CNT_W-1:0]   cnt_q, cur_idx;
  logic [31:0]        crc_q, crc_n;
  logic [DA_BITS-1:0] da_q, da_now, perf_addr;
  logic               take, beyond, decided_b, decide_now, pat_mode;
  logic [NPAT-1:0][PW-1:0] pat_word;
  logic [NPAT-1:0]    lane_hit;
  logic [HASH_IW-1:0] hash_idx;
  logic               hash_bit, chk_accept;
  hit_kind_t          chk_kind;

  assign in_ready   = !dec_valid_q;
  assign take       = in_valid && in_ready && (in_sof || in_frame_q);
  assign cur_idx    = in_sof ? '0 : cnt_q;
  assign beyond     = cur_idx >= CNT_W'(PAT_LEN);
  assign decided_b  = in_sof ? 1'b0 : decided_q;
  assign pat_mode   = |pat_en;
  assign decide_now = take && !decided_b && ((!pat_mode && cur_idx == LAST_DA) || in_eof);

  assign crc_n    = crc32_step(in_sof ? 32'hFFFF_FFFF : crc_q, in_data);
  assign da_now   = (cur_idx == LAST_DA) ? {da_q[DA_BITS-9:0], in_data} : da_q;
  assign hash_idx = (cur_idx == LAST_DA) ? crc_n[31 -: HASH_IW] : crc_q[31 -: HASH_IW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      decided_q  <= 1'b0;
      cnt_q      <= '0;
      crc_q      <= '1;
      da_q       <= '0;
    end else if (take) begin
      in_frame_q <= !in_eof;
      decided_q  <= decided_b || decide_now;
      cnt_q      <= beyond ? cur_idx : cur_idx + 1'b1;
      if (cur_idx <= LAST_DA) begin
        crc_q <= crc_n;
        da_q  <= {da_q[DA_BITS-9:0], in_data};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid_q  <= 1'b0;
      dec_accept_q <= 1'b0;
      dec_kind_q   <= HIT_NONE;
    end else if (decide_now) begin
      dec_valid_q  <= 1'b1;
      dec_accept_q <= chk_accept;
      dec_kind_q   <= chk_kind;
    end else if (dec_ready) begin
      dec_valid_q  <= 1'b0;
    end
  end

  assign dec_valid  = dec_valid_q;
  assign dec_accept = dec_accept_q;
  assign dec_kind   = dec_kind_q;

  rxf_store #(.NPAT(NPAT), .PAT_LEN(PAT_LEN), .HASH_BITS(HASH_BITS)) u_store (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .perf_addr(perf_addr),
    .pat_idx(cur_idx[PAT_IW-1:0]), .pat_word(pat_word),
    .hash_idx(hash_idx), .hash_bit(hash_bit)
  );

  for (genvar p = 0; p < NPAT; p++) begin : g_lane
    rxf_pat_lane u_lane (
      .clk(clk), .rst_n(rst_n), .take(take), .start(in_sof), .beyond(beyond),
      .data(in_data), .word(pat_word[p]), .hit_now(lane_hit[p])
    );
  end

  rxf_da_check u_chk (
    .flt_en(flt_en), .da_ok(cur_idx >= LAST_DA), .da(da_now), .perf_addr(perf_addr),
    .perf_mask(perf_mask), .acc_bcast(acc_bcast), .acc_mcast(acc_mcast),
    .acc_ucast(acc_ucast), .perf_en(perf_en), .hash_mc_en(hash_mc_en),
    .hash_uc_en(hash_uc_en), .hash_bit(hash_bit), .pat_hit(|(lane_hit & pat_en)),
    .accept(chk_accept), .kind(chk_kind)
  );

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_q && !dec_ready) |=> (dec_valid_q && $stable(dec_kind_q) && $stable(dec_accept_q)))
    else $error("decision changed before it was taken");

  assert_after_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_valid_q) |-> $past(in_valid))
    else $error("decision appeared without an offered byte");

  assert_disabled_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dec_valid_q) && !$past(flt_en)) |-> !dec_accept_q)
    else $error("frame accepted with the filter off");

  assert_kind_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_q |-> (dec_accept_q == (dec_kind_q != HIT_NONE)))
    else $error("accept flag and rule code disagree");
endmodule

// File: tb/sim_rx_addr_filter.sv
`timescale 1ns/1ps
module sim_rx_addr_filter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_sof = 0, in_eof = 0, dec_ready = 1;
  logic [7:0] in_data = 0;
  logic in_ready, dec_valid, dec_accept;
  logic [2:0] dec_kind;
  logic flt_en = 0, acc_bcast = 0, acc_mcast = 0, acc_ucast = 0, perf_en = 0;
  logic [5:0] perf_mask = 0;
  logic hash_mc_en = 0, hash_uc_en = 0;
  logic [3:0] pat_en = 0;
  logic cfg_we = 0;
  logic [9:0] cfg_addr = 0;
  logic [15:0] cfg_wdata = 0;
  logic [15:0] cfg_rdata;

  always #2.5 clk = ~clk;

  rx_addr_filter u0 (.*);

  int n_run = 0, n_fail = 0;
  string cur_tag = "R1";
  int hold_cnt = 0;
  bit hs_prev = 0, rd_prev = 0, pv_sof = 0, pv_eof = 0;
  logic [7:0] pv_data = 0;

  // behavioural model state
  logic [7:0] fq[$];
  bit m_in_frame = 0, m_decided = 0;
  bit exp_valid = 0, exp_acc = 0, exp_checked = 0;
  int exp_kind = 0;
  logic [7:0] sh_perf[6];
  logic [9:0] sh_pat[4][64];
  bit sh_hash[2048];

  function automatic logic [31:0] crc_da(input logic [7:0] b[6]);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int k = 0; k < 6; k++)
      for (int i = 0; i < 8; i++) begin
        bit fb = c[0] ^ b[k][i];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    return c;
  endfunction

  task automatic decide();
    int kind = 0;
    if (flt_en && fq.size() >= 6) begin
      logic [47:0] da, pa;
      logic [7:0] db[6];
      bit bc, grp, ph = 1, hh, pt = 0;
      int idx;
      for (int k = 0; k < 6; k++) begin
        db[k] = fq[k];
        da[47-8*k -: 8] = fq[k];
        pa[47-8*k -: 8] = sh_perf[k];
      end
      bc = (da == 48'hFFFF_FFFF_FFFF);
      grp = fq[0][0];
      for (int j = 0; j < 48; j++)
        if (j < 48 - int'(perf_mask) && da[j] != pa[j]) ph = 0;
      ph = ph && perf_en;
      idx = int'(crc_da(db) >> 21);
      hh = sh_hash[idx] && ((grp && hash_mc_en) || (!grp && hash_uc_en));
      for (int p = 0; p < 4; p++) if (pat_en[p]) begin
        bit alive = 1, done = 0;
        for (int i = 0; i < 64 && i < fq.size(); i++) if (!done) begin
          if (sh_pat[p][i][8] && sh_pat[p][i][7:0] != fq[i]) alive = 0;
          if (sh_pat[p][i][9]) done = 1;
        end
        if (alive && done) pt = 1;
      end
      if (bc && acc_bcast) kind = 1;
      else if (grp && !bc && acc_mcast) kind = 2;
      else if (!grp && acc_ucast) kind = 3;
      else if (ph) kind = 4;
      else if (hh) kind = 5;
      else if (pt) kind = 6;
    end
    exp_valid = 1; exp_checked = 0; exp_kind = kind; exp_acc = (kind != 0);
  endtask

  task automatic model_byte(input logic [7:0] b, input bit s, input bit e);
    if (s) begin fq.delete(); m_in_frame = 1; m_decided = 0; end
    else if (!m_in_frame) return;
    fq.push_back(b);
    if (!m_decided) begin
      if (pat_en != 0) begin
        if (e) begin decide(); m_decided = 1; end
      end else if (fq.size() == 6 || e) begin
        decide(); m_decided = 1;
      end
    end
    if (e) m_in_frame = 0;
  endtask

  task automatic cyc();
    @(negedge clk);
    if (hs_prev) model_byte(pv_data, pv_sof, pv_eof);
    if (rd_prev) exp_valid = 0;
    if (dec_valid !== exp_valid || in_ready !== !exp_valid) begin
      n_run++; n_fail++;
      $display("FAIL R1 handshake (%s): dec_valid=%0b in_ready=%0b expected dec_valid=%0b in_ready=%0b",
               cur_tag, dec_valid, in_ready, exp_valid, !exp_valid);
    end
    if (dec_valid && exp_valid && !exp_checked) begin
      exp_checked = 1; n_run++;
      if (dec_accept !== exp_acc || int'(dec_kind) != exp_kind) begin
        n_fail++;
        $display("FAIL %s decision: accept=%0b kind=%0d expected accept=%0b kind=%0d",
                 cur_tag, dec_accept, dec_kind, exp_acc, exp_kind);
      end
    end
  endtask

  task automatic arm();
    dec_ready = (hold_cnt == 0);
    if (hold_cnt > 0) hold_cnt--;
    hs_prev = in_valid && in_ready;
    rd_prev = dec_valid && dec_ready;
    pv_data = in_data; pv_sof = in_sof; pv_eof = in_eof;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      cyc(); in_valid = 0; in_sof = 0; in_eof = 0; cfg_we = 0; arm();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit s, input bit e);
    do begin
      cyc(); in_valid = 1; in_data = b; in_sof = s; in_eof = e; cfg_we = 0; arm();
    end while (!hs_prev);
  endtask

  task automatic send_frame(input logic [7:0] f[$]);
    foreach (f[i]) send_byte(f[i], i == 0, i == f.size() - 1);
    cyc(); in_valid = 0; in_sof = 0; in_eof = 0; arm();
  endtask

  task automatic cfg_write(input logic [9:0] a, input logic [15:0] d);
    cyc(); in_valid = 0; cfg_we = 1; cfg_addr = a; cfg_wdata = d; arm();
    if (a < 3) begin sh_perf[2*a] = d[7:0]; sh_perf[2*a+1] = d[15:8]; end
    else if (a >= 10'h100 && a < 10'h200) sh_pat[(a-10'h100)/64][(a-10'h100)%64] = d[9:0];
    else if (a >= 10'h200 && a < 10'h280)
      for (int i = 0; i < 16; i++) sh_hash[(a-10'h200)*16+i] = d[i];
    cyc(); cfg_we = 0; arm();
  endtask

  task automatic cfg_check(input logic [9:0] a, input logic [15:0] e, input string tag);
    cyc(); cfg_addr = a; arm();
    #1;
    n_run++;
    if (cfg_rdata !== e) begin
      n_fail++;
      $display("FAIL %s readback @%h: got %h expected %h", tag, a, cfg_rdata, e);
    end
  endtask

  function automatic logic [7:0] q8(input int v); return v[7:0]; endfunction

  task automatic frame_da(input logic [47:0] da, input int len);
    logic [7:0] f[$];
    for (int k = 0; k < len; k++) f.push_back(k < 6 ? da[47-8*k -: 8] : q8(k * 7 + 3));
    send_frame(f);
  endtask

  task automatic set_hash(input logic [47:0] da);
    logic [7:0] b[6];
    int idx, w;
    logic [15:0] d;
    for (int k = 0; k < 6; k++) b[k] = da[47-8*k -: 8];
    idx = int'(crc_da(b) >> 21);
    w = idx / 16;
    for (int i = 0; i < 16; i++) d[i] = sh_hash[w*16+i];
    d[idx%16] = 1'b1;
    cfg_write(10'(10'h200 + w), d);
  endtask

  localparam logic [47:0] BC = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MC = 48'h0100_5E00_0001;
  localparam logic [47:0] M2 = 48'h3333_0000_00FB;
  localparam logic [47:0] UC = 48'h001B_21AA_BBCC;
  localparam logic [47:0] ST = 48'h1234_5678_9ABC;
  localparam logic [47:0] SX = 48'h0234_5678_9ABC;

  initial begin
    foreach (sh_perf[i]) sh_perf[i] = 0;
    foreach (sh_pat[p, i]) sh_pat[p][i] = 0;
    foreach (sh_hash[i]) sh_hash[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    cur_tag = "R1";
    idle(2);
    cfg_check(10'h000, 16'h0000, "R11");
    // R11 store map
    cfg_write(10'h000, 16'h3412);
    cfg_write(10'h001, 16'h7856);
    cfg_write(10'h002, 16'hBC9A);
    cfg_check(10'h001, 16'h7856, "R11");
    cfg_write(10'h300, 16'hFFFF);
    cfg_check(10'h300, 16'h0000, "R11");
    cfg_write(10'h140, 16'hFFFF);
    cfg_check(10'h140, 16'h03FF, "R11");
    // R3 filter off
    cur_tag = "R3"; acc_bcast = 1; flt_en = 0;
    frame_da(BC, 8);
    // R4 broadcast
    cur_tag = "R4"; flt_en = 1;
    frame_da(BC, 8);
    // R5 multicast, broadcast not caught
    cur_tag = "R5"; acc_bcast = 0; acc_mcast = 1;
    frame_da(MC, 8);
    frame_da(BC, 8);
    // R6 unicast
    cur_tag = "R6"; acc_mcast = 0; acc_ucast = 1;
    frame_da(UC, 9);
    frame_da(MC, 9);
    // R7 station compare and mask
    cur_tag = "R7"; acc_ucast = 0; perf_en = 1; perf_mask = 0;
    frame_da(ST, 10);
    frame_da(SX, 10);
    idle(2); perf_mask = 8;
    frame_da(SX, 10);
    // R8 hash
    cur_tag = "R8"; idle(2); perf_en = 0; perf_mask = 0;
    set_hash(UC); set_hash(M2);
    hash_uc_en = 1;
    frame_da(UC, 8);
    idle(2); hash_uc_en = 0; hash_mc_en = 1;
    frame_da(UC, 8);
    frame_da(M2, 8);
    hash_mc_en = 0;
    // R9 patterns
    cur_tag = "R9";
    cfg_write(10'h100 + 12, 16'h0108);
    cfg_write(10'h100 + 13, 16'h0300);
    cfg_check(10'h10D, 16'h0300, "R11");
    pat_en = 4'b0001;
    begin
      logic [7:0] f[$];
      for (int k = 0; k < 20; k++) f.push_back(q8(k + 40));
      f[12] = 8'h08; f[13] = 8'h00;
      send_frame(f);
      f[13] = 8'h06;
      send_frame(f);
      f[13] = 8'h00;
      while (f.size() > 13) void'(f.pop_back());
      send_frame(f);
    end
    // R10 priority
    cur_tag = "R10"; idle(2); pat_en = 0;
    cfg_write(10'h000, 16'hFFFF); cfg_write(10'h001, 16'hFFFF); cfg_write(10'h002, 16'hFFFF);
    acc_bcast = 1; perf_en = 1;
    frame_da(BC, 8);
    idle(2); acc_bcast = 0; perf_en = 0; acc_mcast = 1; hash_mc_en = 1;
    frame_da(M2, 8);
    idle(2); acc_mcast = 0;
    frame_da(M2, 8);
    // R2 short frame and loose bytes
    cur_tag = "R2"; idle(2); hash_mc_en = 0; acc_ucast = 1;
    frame_da(UC, 4);
    cur_tag = "R1";
    send_byte(8'hAA, 0, 0); send_byte(8'h55, 0, 0); send_byte(8'h01, 0, 1);
    frame_da(UC, 6);
    // R1 stalled consumer and back-to-back frames
    hold_cnt = 6;
    frame_da(UC, 12);
    frame_da(ST, 7);
    hold_cnt = 3;
    frame_da(MC, 7);
    idle(10);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL R1 watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule